// File: doc/BRIEF.md
# Standby pin buffer controller

This block sits beside one I/O port and decides what each pin's output buffer and input buffer do while the chip is in a low-power standby state. Software fills a per-port drive register ahead of time, one bit per pin. When the processor issues its halt, the block combines each pin's drive bit with that pin's output enable as it stood just before standby. It holds the result on the buffer enables until a wake event arrives. The same freeze applies in every standby flavour, so the block has no mode input.

Outside standby the block passes normal direction control through. The output buffer follows the port's output enable, and the input buffer is enabled whenever the output buffer is not. A system reset sets the drive register to all ones. A hot reset drops the port out of standby and leaves the register contents as they were.

Top module: `stby_pin_buf_ctrl`

## Requirements
- R1: After system reset (rst_n low), every drive register bit reads 1 (rd_data = 8'hFF) and the port is not in standby.
- R2: When wr_en is high at a rising clock edge, wr_data is stored, and rd_data shows it from the next cycle on, whether or not the port is in standby.
- R3: Outside standby, out_buf_en equals oe_in and in_buf_en equals ~oe_in, bit for bit, in the same cycle.
- R4: When halt_stb is high, wake is low and hot_rst_n is high at a rising edge while the port is not in standby, standby starts on the next cycle. Bit n of the drive register governs pin n, giving these frozen enables for each pin: oe=1 and drive=1 turn the output on and the input off; oe=0 and drive=1 turn the output off and the input on; drive=0 turns both off.
- R5: The freeze uses oe_in as sampled at the halt edge and the drive register contents from before that edge. A write in the halt cycle counts only for a later halt.
- R6: During standby, changes on oe_in and writes to the drive register leave out_buf_en and in_buf_en unchanged.
- R7: When wake goes high during standby, normal buffer control (R3) returns in that same cycle, and the port stays out of standby from the next edge on.
- R8: halt_stb has no effect while the port is already in standby, so there is no recapture. It also has no effect when it arrives together with wake.
- R9: hot_rst_n low at a rising edge ends standby from the next cycle, clears any frozen state, and leaves the drive register unchanged.
- R10: No pin ever has both its output buffer and its input buffer enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low, synchronous |
| hot_rst_n | input | 1 | Hot reset, active low, synchronous; keeps drive register |
| wr_en | input | 1 | Drive register write strobe |
| wr_data | input | 8 | Drive register write data, bit n for pin n |
| rd_data | output | 8 | Drive register read-back |
| oe_in | input | 8 | Per-pin output enable from the port direction register |
| halt_stb | input | 1 | Standby entry strobe from halt execution |
| wake | input | 1 | Wake request ending standby |
| out_buf_en | output | 8 | Per-pin output buffer enable |
| in_buf_en | output | 8 | Per-pin input buffer enable |

## Verification
The buffer enables respond to oe_in and wake in the same cycle. Standby entry, the frozen values, hot reset exit and register writes show up one cycle after the edge that samples them. The scoreboard driver applies inputs just after a falling edge. At that moment it pushes the outputs due in that same cycle, computed from a bench model that holds the state left by the previous rising edge. It then advances that model across the coming edge. The monitor samples 2 ns after the falling edge and before the next rising edge, so each comparison sees exactly one edge's worth of register updates.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef struct packed {
    logic obuf;
    logic ibuf;
  } buf_pair_t;

  // Frozen standby decode: output only when enabled and driven,
  // input only when not enabled and driven, nothing when drive is 0.
  function automatic buf_pair_t standby_pair(input logic oe, input logic drv);
    buf_pair_t r;
    r.obuf = oe & drv;
    r.ibuf = ~oe & drv;
    return r;
  endfunction

  // Normal operation: input buffer listens whenever the output is idle.
  function automatic buf_pair_t run_pair(input logic oe);
    buf_pair_t r;
    r.obuf = oe;
    r.ibuf = ~oe;
    return r;
  endfunction

endpackage

// File: rtl/stby_drive_reg.sv
module stby_drive_reg #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PINS-1:0] wr_data,
  output logic [PINS-1:0] drv_q
);

  localparam logic [PINS-1:0] RESET_VAL = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)     drv_q <= RESET_VAL;
    else if (wr_en) drv_q <= wr_data;
  end

  assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> drv_q == RESET_VAL);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> drv_q == $past(wr_data));

endmodule

// File: rtl/stby_mode_ctrl.sv
module stby_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_rst_n,
  input  logic halt_stb,
  input  logic wake,
  output logic stby_q,
  output logic enter_evt,
  output logic exit_evt,
  output logic stby_act
);

  assign enter_evt = !stby_q && halt_stb && !wake && hot_rst_n;
  assign exit_evt  = stby_q && wake;
  assign stby_act  = stby_q && !wake;

  always_ff @(posedge clk) begin
    if (!rst_n)          stby_q <= 1'b0;
    else if (!hot_rst_n) stby_q <= 1'b0;
    else if (enter_evt)  stby_q <= 1'b1;
    else if (exit_evt)   stby_q <= 1'b0;
  end

  assert_wake_exits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_q && wake) |=> !stby_q);

  assert_stby_persists_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_q && !wake && hot_rst_n) |=> stby_q);

  assert_halt_wake_clash_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_q && wake) |=> !stby_q);

endmodule

// File: rtl/stby_buf_freeze.sv
module stby_buf_freeze
  import stby_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hot_rst_n,
  input  logic            capture,
  input  logic            stby_act,
  input  logic [PINS-1:0] oe_in,
  input  logic [PINS-1:0] drv,
  output logic [PINS-1:0] obuf,
  output logic [PINS-1:0] ibuf
);

  logic [PINS-1:0] frz_o;
  logic [PINS-1:0] frz_i;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    buf_pair_t nxt_frz;
    buf_pair_t live;

    assign nxt_frz = standby_pair(oe_in[p], drv[p]);
    assign live    = run_pair(oe_in[p]);

    always_ff @(posedge clk) begin
      if (!rst_n || !hot_rst_n) begin
        frz_o[p] <= 1'b0;
        frz_i[p] <= 1'b0;
      end else if (capture) begin
        frz_o[p] <= nxt_frz.obuf;
        frz_i[p] <= nxt_frz.ibuf;
      end
    end

    assign obuf[p] = stby_act ? frz_o[p] : live.obuf;
    assign ibuf[p] = stby_act ? frz_i[p] : live.ibuf;
  end

  assert_no_dual_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (obuf & ibuf) == '0);

  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_act && $past(stby_act)) |-> ($stable(obuf) && $stable(ibuf)));

  assert_capture_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (!stby_act ||
                 (obuf == $past(oe_in & drv) && ibuf == $past(~oe_in & drv))));

endmodule

// File: rtl/stby_pin_buf_ctrl.sv
module stby_pin_buf_ctrl #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hot_rst_n,
  input  logic            wr_en,
  input  logic [PINS-1:0] wr_data,
  output logic [PINS-1:0] rd_data,
  input  logic [PINS-1:0] oe_in,
  input  logic            halt_stb,
  input  logic            wake,
  output logic [PINS-1:0] out_buf_en,
  output logic [PINS-1:0] in_buf_en
);

  logic [PINS-1:0] drv_q;
  logic            stby_q;
  logic            enter_evt;
  logic            exit_evt;
  logic            stby_act;

  stby_drive_reg #(.PINS(PINS)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .drv_q   (drv_q)
  );

  stby_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .hot_rst_n (hot_rst_n),
    .halt_stb  (halt_stb),
    .wake      (wake),
    .stby_q    (stby_q),
    .enter_evt (enter_evt),
    .exit_evt  (exit_evt),
    .stby_act  (stby_act)
  );

  stby_buf_freeze #(.PINS(PINS)) u_freeze (
    .clk       (clk),
    .rst_n     (rst_n),
    .hot_rst_n (hot_rst_n),
    .capture   (enter_evt),
    .stby_act  (stby_act),
    .oe_in     (oe_in),
    .drv       (drv_q),
    .obuf      (out_buf_en),
    .ibuf      (in_buf_en)
  );

  assign rd_data = drv_q;

  assert_run_follows_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_q |-> (out_buf_en == oe_in && in_buf_en == ~oe_in));

  assert_wake_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (out_buf_en == oe_in && in_buf_en == ~oe_in));

  assert_hot_keeps_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hot_rst_n && !wr_en) |=> $stable(rd_data));

  assert_hot_leaves_stby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hot_rst_n |=> !stby_q);

endmodule

// File: tb/test_stby_pin_buf_ctrl.sv
`timescale 1ns/1ps
module test_stby_pin_buf_ctrl;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hot_rst_n = 1'b1;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] oe_in = '0;
  logic         halt_stb = 1'b0;
  logic         wake = 1'b0;
  logic [W-1:0] out_buf_en;
  logic [W-1:0] in_buf_en;

  always #4 clk = ~clk;

  stby_pin_buf_ctrl #(.PINS(W)) i_stby_pin_buf_ctrl (
    .clk(clk), .rst_n(rst_n), .hot_rst_n(hot_rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .oe_in(oe_in), .halt_stb(halt_stb), .wake(wake),
    .out_buf_en(out_buf_en), .in_buf_en(in_buf_en)
  );

  typedef struct packed {
    logic [W-1:0] o;
    logic [W-1:0] i;
    logic [W-1:0] r;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  // bench model state, as left by the most recent rising edge
  logic [W-1:0] m_drv = '1;
  logic         m_stby = 1'b0;
  logic [W-1:0] m_fo = '0;
  logic [W-1:0] m_fi = '0;

  task automatic step(input logic wr, input logic [W-1:0] wd, input logic h,
                      input logic wk, input logic [W-1:0] oe, input logic hot_n,
                      input string tag);
    exp_t e;
    logic act;
    @(negedge clk);
    wr_en = wr; wr_data = wd; halt_stb = h; wake = wk; oe_in = oe; hot_rst_n = hot_n;
    act = m_stby && !wk;
    e.o = act ? m_fo : oe;
    e.i = act ? m_fi : ~oe;
    e.r = m_drv;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    // advance the model across the coming edge
    if (!hot_n) begin
      m_stby = 1'b0; m_fo = '0; m_fi = '0;
    end else if (!m_stby && h && !wk) begin
      for (int b = 0; b < W; b++) begin
        m_fo[b] = (oe[b] == 1'b1) && (m_drv[b] == 1'b1);
        m_fi[b] = (oe[b] == 1'b0) && (m_drv[b] == 1'b1);
      end
      m_stby = 1'b1;
    end else if (m_stby && wk) begin
      m_stby = 1'b0;
    end
    if (wr) m_drv = wd;
  endtask

  initial begin : monitor
    exp_t  e;
    string t;
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (out_buf_en !== e.o || in_buf_en !== e.i || rd_data !== e.r) begin
          failures++;
          $display("FAIL %s: out=%h in=%h rd=%h expected out=%h in=%h rd=%h",
                   t, out_buf_en, in_buf_en, rd_data, e.o, e.i, e.r);
        end
        checks++;
        if ((out_buf_en & in_buf_en) !== '0) begin
          failures++;
          $display("FAIL R10: out&in=%h expected 00", out_buf_en & in_buf_en);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 8'h00, 0, 0, 8'h0F, 1, "R1 reset state");
    step(1, 8'h5A, 0, 0, 8'h3C, 1, "R3 normal control");
    step(0, 8'h00, 0, 0, 8'hC3, 1, "R2 write read-back");
    step(1, 8'hFF, 1, 0, 8'h33, 1, "R5 halt with same-cycle write");
    step(0, 8'h00, 0, 0, 8'hFF, 1, "R4 frozen table");
    step(1, 8'h00, 0, 0, 8'h00, 1, "R6 oe and write ignored");
    step(0, 8'h00, 1, 0, 8'hAA, 1, "R8 halt in standby ignored");
    step(0, 8'h00, 0, 0, 8'h99, 1, "R6 R8 still frozen");
    step(0, 8'h00, 0, 1, 8'h0F, 1, "R7 wake same cycle");
    step(0, 8'h00, 1, 1, 8'h0F, 1, "R8 halt with wake");
    step(0, 8'h00, 0, 0, 8'h55, 1, "R8 no standby after clash");
    step(1, 8'hF0, 0, 0, 8'h55, 1, "R2 write");
    step(0, 8'h00, 1, 0, 8'h3C, 1, "R4 enter");
    step(0, 8'h00, 0, 0, 8'h00, 1, "R4 frozen second pattern");
    step(0, 8'h00, 0, 0, 8'h00, 0, "R9 hot reset cycle");
    step(0, 8'h00, 0, 0, 8'hA5, 1, "R9 out of standby, drive kept");
    step(0, 8'h00, 1, 0, 8'hA5, 0, "R9 hot reset beats halt");
    step(0, 8'h00, 0, 0, 8'h5A, 1, "R9 no standby");
    for (int k = 0; k < 16; k++) begin
      step(1, 8'(k * 37 + 3), 0, 0, 8'(k * 11), 1, "R2 sweep write");
      step(0, 8'h00, 1, 0, 8'(k * 91 + 5), 1, "R4 sweep halt");
      step(0, 8'h00, 0, 0, ~8'(k * 91 + 5), 1, "R4 R6 sweep frozen");
      step(0, 8'h00, 0, 1, 8'(k * 29), 1, "R7 sweep wake");
    end
    step(0, 8'h00, 0, 0, 8'h81, 1, "R3 final");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule